// File: doc/BRIEF.md
# Three-Mode Level-One Instruction Memory

This block is the instruction store that sits next to a core's fetch stage. It holds one array of instruction words and serves fetches from it in one of three modes. In self-test mode, which it enters on reset, the lower half of the array is loaded with a fixed boot program. A core with no external memory can therefore fetch and run that program. Each time the block returns the program's toggle instruction, a dedicated liveness pin inverts. In scratchpad mode the array is a plain addressed store that software fills through the debug port. In cache mode the same array becomes a direct-mapped cache with per-line valid bits and tags, refilled over a simple line request and beat response port.

Fetch addresses are byte addresses. Instruction slots are 8 bytes apart, so address bits [2:0] are ignored. A debug port gives direct read and write access to every array row and to the mode register. A fetch is accepted when `fetch_ready` is high. The response comes on `fetch_valid`/`fetch_word`.

Top module: `tri_mode_imem`

## Requirements
- R1: After reset the mode register reads 0 (self-test). `fetch_valid`, `mem_req` and `alive_out` are low and `fetch_ready` is high.
- R2: In self-test mode (mode 0) a fetch of slot i (byte address 8*i, i < 32) returns the boot word for that slot, one cycle after acceptance. Each word is encoded as op<<28 | rd<<24 | rs<<20 | imm, with ops nop=0, addi=1, store=2, load=3, toggle=4, jump=5. The program by slot is: 0..3 addi r1..r4 from r0 with imm 0; 4 toggle; 5..7 nop; 8 store rd=r4 rs=r3; 9 addi r2,r2,10; 10 addi r1,r1,5; 11 addi r2,r2,10; 12 toggle; 13 addi r1,r1,5; 14 addi r2,r2,10; 15 addi r1,r1,5; 16 addi r4,r0,0; 17 load rd=r4 rs=r3; 18 addi r1,r1,5; 19 addi r2,r2,10; 20 toggle; 21 addi r2,r2,10; 22 addi r4,r4,2; 23 addi r3,r3,4; 24 addi r2,r2,10; 25 addi r1,r1,5; 26 addi r1,r1,5; 27 jump imm 0x40; 28..31 nop.
- R3: In self-test mode a fetch of any row at or above 32 returns zero, even after that row has been written through the debug port.
- R4: `alive_out` inverts in the same cycle that `fetch_valid` presents a word whose bits [31:28] equal 4, in any mode. Otherwise it holds its value.
- R5: In scratchpad mode (mode 2) a fetch of row `addr[8:3]` returns that row's current contents one cycle after acceptance, with back-to-back fetches accepted every cycle. In modes 0 and 2 `mem_req` never rises.
- R6: In cache mode (mode 1) a miss drops `fetch_ready` and raises `mem_req` for exactly one cycle, starting the cycle after acceptance. In that cycle `mem_line_addr` carries the miss address with bits [4:0] cleared. The line is filled from 4 beats on `mem_rvalid`/`mem_rdata`, in ascending slot order. The response comes one cycle after the edge that takes the last beat, and then `fetch_ready` returns high.
- R7: In cache mode, a fetch whose line index `addr[8:5]` is valid with a matching tag `addr[15:9]` is a hit. A hit responds one cycle after acceptance and raises no `mem_req`.
- R8: Any accepted write to the mode register clears every valid bit, so a line that hit before a mode change misses afterwards.
- R9: A debug write with address bit 6 set writes the mode from `dbg_wdata[1:0]`. The value 3 is not a mode, and writing it leaves the mode and valid bits unchanged.
- R10: `dbg_rdata` gives, in the same cycle, the mode zero-extended when `dbg_addr[6]` is 1, and otherwise array row `dbg_addr[5:0]`. A debug write with `dbg_addr[6]` clear stores `dbg_wdata` into that row.
- R11: Reset restores the boot words in rows 0..31 even if they were overwritten beforehand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, taken when fetch_ready is high |
| fetch_addr | input | 16 | Fetch byte address |
| fetch_ready | output | 1 | Block can accept a fetch |
| fetch_valid | output | 1 | Response word valid |
| fetch_word | output | 32 | Response instruction word |
| mem_req | output | 1 | One-cycle line refill request |
| mem_line_addr | output | 16 | Byte address of the requested line |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | 32 | Refill beat data |
| dbg_addr | input | 7 | Debug address: bit 6 selects mode register, else row |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data, combinational |
| alive_out | output | 1 | Liveness pin, inverts on each returned toggle word |

## Verification
Hits and all scratchpad or self-test fetches respond exactly one cycle after the accepting edge, and `alive_out` flips at that same edge. A miss puts `mem_req` in the next cycle and answers one cycle after the last refill beat. Debug reads are due in the same cycle, and mode writes take effect at the next edge. The bench's behavioural model advances once per rising edge using the inputs held across it, and compares every output at the following falling edge. Each result is therefore checked in exactly the cycle it is due, including across the refill's irregular beat gaps.

// File: rtl/tri_mode_imem.sv
`timescale 1ns/1ps
module tri_mode_imem #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int ROWS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int PRESET_N   = 32,
  parameter int SLOT_SHIFT = 3,
  localparam int ROW_AW  = $clog2(ROWS),
  localparam int LW_AW   = $clog2(LINE_WORDS),
  localparam int LINES   = ROWS / LINE_WORDS,
  localparam int IDX_AW  = $clog2(LINES),
  localparam int LINE_LO = SLOT_SHIFT + LW_AW,
  localparam int TAG_LO  = SLOT_SHIFT + ROW_AW,
  localparam int TAG_W   = ADDR_W - TAG_LO,
  localparam int DBG_AW  = ROW_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              fetch_valid,
  output logic [WORD_W-1:0] fetch_word,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_line_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [DBG_AW-1:0] dbg_addr,
  input  logic              dbg_we,
  input  logic [WORD_W-1:0] dbg_wdata,
  output logic [WORD_W-1:0] dbg_rdata,
  output logic              alive_out
);
  localparam logic [1:0] MODE_TEST    = 2'd0;
  localparam logic [1:0] MODE_CACHE   = 2'd1;
  localparam logic [3:0] OP_TOGGLE    = 4'h4;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL, S_DONE} st_t;

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                      input logic [3:0] rs, input logic [15:0] imm);
    return {op, rd, rs, 4'h0, imm};
  endfunction

  function automatic logic [31:0] boot_word(input int i);
    case (i)
      0:  return enc(4'h1, 4'd1, 4'd0, 16'd0);
      1:  return enc(4'h1, 4'd2, 4'd0, 16'd0);
      2:  return enc(4'h1, 4'd3, 4'd0, 16'd0);
      3:  return enc(4'h1, 4'd4, 4'd0, 16'd0);
      4, 12, 20: return enc(4'h4, 4'd0, 4'd0, 16'd0);
      8:  return enc(4'h2, 4'd4, 4'd3, 16'd0);
      9, 11, 14, 19, 21, 24: return enc(4'h1, 4'd2, 4'd2, 16'd10);
      10, 13, 15, 18, 25, 26: return enc(4'h1, 4'd1, 4'd1, 16'd5);
      16: return enc(4'h1, 4'd4, 4'd0, 16'd0);
      17: return enc(4'h3, 4'd4, 4'd3, 16'd0);
      22: return enc(4'h1, 4'd4, 4'd4, 16'd2);
      23: return enc(4'h1, 4'd3, 4'd3, 16'd4);
      27: return enc(4'h5, 4'd0, 4'd0, 16'h0040);
      default: return 32'h0;
    endcase
  endfunction

  logic [1:0]        mode_q;
  logic [WORD_W-1:0] arr [ROWS];
  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  st_t               st_q;
  logic [LW_AW-1:0]  beat_q;
  logic [ADDR_W-1:0] pend_q;

  logic [ROW_AW-1:0] req_row, pend_row, fill_row, dbg_row;
  logic [IDX_AW-1:0] req_line, pend_line;
  logic [TAG_W-1:0]  req_tag;
  logic              hit, rsp_fire, miss, cfg_wr, row_wr;
  logic [WORD_W-1:0] sp_word, rsp_data;
  logic              unused_ok;

  assign req_row   = fetch_addr[SLOT_SHIFT +: ROW_AW];
  assign req_line  = fetch_addr[LINE_LO +: IDX_AW];
  assign req_tag   = fetch_addr[TAG_LO +: TAG_W];
  assign pend_row  = pend_q[SLOT_SHIFT +: ROW_AW];
  assign pend_line = pend_q[LINE_LO +: IDX_AW];
  assign fill_row  = {pend_line, beat_q};
  assign dbg_row   = dbg_addr[ROW_AW-1:0];
  assign unused_ok = ^{fetch_addr[SLOT_SHIFT-1:0], pend_q[SLOT_SHIFT-1:0]};

  assign hit      = vld_q[req_line] && (tag_q[req_line] == req_tag);
  assign sp_word  = (mode_q == MODE_TEST && 32'(req_row) >= PRESET_N) ? '0 : arr[req_row];
  assign rsp_fire = (st_q == S_IDLE && fetch_req && (mode_q != MODE_CACHE || hit)) || st_q == S_DONE;
  assign miss     = st_q == S_IDLE && fetch_req && mode_q == MODE_CACHE && !hit;
  assign rsp_data = (st_q == S_DONE) ? arr[pend_row] : sp_word;
  assign cfg_wr   = dbg_we && dbg_addr[DBG_AW-1] && dbg_wdata[1:0] != 2'd3;
  assign row_wr   = dbg_we && !dbg_addr[DBG_AW-1];

  assign fetch_ready   = st_q == S_IDLE;
  assign mem_req       = st_q == S_REQ;
  assign mem_line_addr = {pend_q[ADDR_W-1:LINE_LO], {LINE_LO{1'b0}}};
  assign dbg_rdata     = dbg_addr[DBG_AW-1] ? WORD_W'(mode_q) : arr[dbg_row];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++)
        arr[i] <= (i < PRESET_N) ? WORD_W'(boot_word(i)) : '0;
    end else begin
      if (st_q == S_FILL && mem_rvalid) arr[fill_row] <= mem_rdata;
      if (row_wr) arr[dbg_row] <= dbg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_TEST;
      vld_q       <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
      st_q        <= S_IDLE;
      beat_q      <= '0;
      pend_q      <= '0;
      fetch_valid <= 1'b0;
      fetch_word  <= '0;
      alive_out   <= 1'b0;
    end else begin
      fetch_valid <= rsp_fire;
      if (rsp_fire) fetch_word <= rsp_data;
      alive_out <= alive_out ^ (rsp_fire && rsp_data[WORD_W-1 -: 4] == OP_TOGGLE);
      case (st_q)
        S_IDLE: if (miss) begin
          st_q   <= S_REQ;
          pend_q <= fetch_addr;
        end
        S_REQ: begin
          st_q   <= S_FILL;
          beat_q <= '0;
        end
        S_FILL: if (mem_rvalid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LW_AW'(LINE_WORDS - 1)) begin
            vld_q[pend_line] <= 1'b1;
            tag_q[pend_line] <= pend_q[TAG_LO +: TAG_W];
            st_q             <= S_DONE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (cfg_wr) begin
        mode_q <= dbg_wdata[1:0];
        vld_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/tri_mode_imem_chk.sv
`timescale 1ns/1ps
module tri_mode_imem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_req,
  input logic       fetch_ready,
  input logic       fetch_valid,
  input logic [3:0] fetch_op,
  input logic       mem_req,
  input logic       alive_out,
  input logic [1:0] mode_q
);
  p_no_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd1) |-> !mem_req);

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !fetch_ready);

  p_sp_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ready && mode_q != 2'd1) |=> fetch_valid);

  p_alive_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_op == 4'h4) |-> (alive_out != $past(alive_out)));

  p_alive_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> $stable(alive_out));

  p_mode_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3);
endmodule

bind tri_mode_imem tri_mode_imem_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .fetch_req(fetch_req),
  .fetch_ready(fetch_ready),
  .fetch_valid(fetch_valid),
  .fetch_op(fetch_word[WORD_W-1 -: 4]),
  .mem_req(mem_req),
  .alive_out(alive_out),
  .mode_q(mode_q)
);

// File: tb/tri_mode_imem_bench.sv
`timescale 1ns/1ps
module tri_mode_imem_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        fetch_ready, fetch_valid, mem_req, alive_out;
  logic [31:0] fetch_word, dbg_rdata;
  logic [15:0] mem_line_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [6:0]  dbg_addr = '0;
  logic        dbg_we = 1'b0;
  logic [31:0] dbg_wdata = '0;

  always #2.5 clk = ~clk;

  tri_mode_imem u_tri_mode_imem (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .mem_req(mem_req), .mem_line_addr(mem_line_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .dbg_addr(dbg_addr), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .alive_out(alive_out)
  );

  int    checks = 0, errors = 0;
  string cur = "R1";
  bit    finished = 0;

  int          m_mode, m_st, m_beat, m_pend;
  logic [31:0] m_arr [64];
  bit          m_vld [16];
  int          m_tag [16];
  bit          e_valid, m_alive;
  logic [31:0] e_word;

  int rsp_left = 0, rsp_delay = 0, rsp_idx = 0, mreq_count = 0;
  logic [15:0] rsp_base = '0;

  function automatic logic [31:0] e(int op, int rd, int rs, int imm);
    return {op[3:0], rd[3:0], rs[3:0], 4'h0, imm[15:0]};
  endfunction

  function automatic logic [31:0] tb_boot(int i);
    if (i < 4) return e(1, i + 1, 0, 0);
    case (i)
      4, 12, 20: return e(4, 0, 0, 0);
      8:  return e(2, 4, 3, 0);
      9, 11, 14, 19, 21, 24: return e(1, 2, 2, 10);
      10, 13, 15, 18, 25, 26: return e(1, 1, 1, 5);
      16: return e(1, 4, 0, 0);
      17: return e(3, 4, 3, 0);
      22: return e(1, 4, 4, 2);
      23: return e(1, 3, 3, 4);
      27: return e(5, 0, 0, 16'h40);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] memf(logic [15:0] a);
    return 32'h6A00_0000 ^ {16'h0, a} ^ {a, 16'h0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_st = 0; m_beat = 0; m_pend = 0;
    for (int i = 0; i < 64; i++) m_arr[i] = (i < 32) ? tb_boot(i) : 32'h0;
    for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_tag[i] = 0; end
    e_valid = 0; e_word = 0; m_alive = 0;
  endtask

  task automatic model_step();
    int row, line, tg;
    bit fire;
    logic [31:0] w;
    fire = 0; w = 0;
    case (m_st)
      0: if (fetch_req) begin
        row = (fetch_addr >> 3) & 63; line = (fetch_addr >> 5) & 15; tg = fetch_addr >> 9;
        if (m_mode != 1) begin
          fire = 1; w = (m_mode == 0 && row >= 32) ? 32'h0 : m_arr[row];
        end else if (m_vld[line] && m_tag[line] == tg) begin
          fire = 1; w = m_arr[row];
        end else begin
          m_st = 1; m_pend = fetch_addr;
        end
      end
      1: begin m_st = 2; m_beat = 0; end
      2: if (mem_rvalid) begin
        line = (m_pend >> 5) & 15;
        m_arr[line * 4 + m_beat] = mem_rdata;
        m_beat++;
        if (m_beat == 4) begin m_vld[line] = 1; m_tag[line] = m_pend >> 9; m_st = 3; end
      end
      default: begin fire = 1; w = m_arr[(m_pend >> 3) & 63]; m_st = 0; end
    endcase
    e_valid = fire;
    if (fire) begin
      e_word = w;
      if (w[31:28] == 4'h4) m_alive = ~m_alive;
    end
    if (dbg_we) begin
      if (dbg_addr[6]) begin
        if (dbg_wdata[1:0] != 2'd3) begin
          m_mode = dbg_wdata[1:0];
          for (int i = 0; i < 16; i++) m_vld[i] = 0;
        end
      end else m_arr[dbg_addr[5:0]] = dbg_wdata;
    end
  endtask

  task automatic compare();
    check(cur, 32'(fetch_valid), 32'(e_valid));
    if (e_valid) check(cur, fetch_word, e_word);
    check(cur, 32'(fetch_ready), 32'(m_st == 0));
    check(cur, 32'(mem_req), 32'(m_st == 1));
    if (m_st == 1) check(cur, 32'(mem_line_addr), 32'(m_pend & 16'hFFE0));
    check(cur, 32'(alive_out), 32'(m_alive));
    check({cur, "/R10"}, dbg_rdata, dbg_addr[6] ? 32'(m_mode) : m_arr[dbg_addr[5:0]]);
  endtask

  task automatic responder();
    if (mem_req) begin
      rsp_left = 4; rsp_idx = 0; rsp_delay = 2; rsp_base = mem_line_addr; mreq_count++;
    end
    mem_rvalid = 1'b0;
    if (rsp_left > 0) begin
      if (rsp_delay > 0) rsp_delay--;
      else begin
        mem_rvalid = 1'b1;
        mem_rdata  = memf(rsp_base + 16'(8 * rsp_idx));
        rsp_idx++; rsp_left--;
        rsp_delay = rsp_idx % 2;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    if (rst_n) compare();
    responder();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fetch_req = 0; dbg_we = 0; dbg_addr = 0; mem_rvalid = 0; rsp_left = 0;
    model_reset();
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
  endtask

  task automatic fetch(input logic [15:0] a, output logic [31:0] w);
    int n;
    n = 0;
    while (!fetch_ready && n < 50) begin tick(); n++; end
    fetch_req = 1'b1; fetch_addr = a;
    tick();
    fetch_req = 1'b0;
    n = 0;
    while (!fetch_valid && n < 50) begin tick(); n++; end
    w = fetch_word;
  endtask

  task automatic dbg_write(input logic [6:0] a, input logic [31:0] d);
    dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    tick();
    dbg_we = 1'b0;
  endtask

  task automatic dbg_check(string tag, input logic [6:0] a, input logic [31:0] exp);
    dbg_addr = a;
    #1;
    check(tag, dbg_rdata, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements): run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    int base;
    do_reset();
    cur = "R1";
    check("R1 valid", 32'(fetch_valid), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 alive", 32'(alive_out), 0);
    check("R1 ready", 32'(fetch_ready), 1);
    dbg_check("R1 mode", 7'h40, 32'd0);
    tick();

    cur = "R2";
    for (int i = 0; i < 32; i++) begin
      fetch(16'(i * 8), w);
      check("R2 boot word", w, tb_boot(i));
    end
    check("R4 alive after three toggles", 32'(alive_out), 1);

    cur = "R3";
    fetch(16'h0140, w);
    check("R3 upper row zero", w, 0);
    dbg_write(7'd40, 32'hDEAD_0040);
    fetch(16'h0140, w);
    check("R3 written upper row still zero", w, 0);
    dbg_check("R10 row readback", 7'd40, 32'hDEAD_0040);

    cur = "R9";
    dbg_write(7'h40, 32'h3);
    dbg_check("R9 illegal mode ignored", 7'h40, 32'd0);

    cur = "R5";
    dbg_write(7'h40, 32'h2);
    dbg_check("R5 mode scratch", 7'h40, 32'd2);
    fetch(16'h0140, w);
    check("R5 scratch row 40", w, 32'hDEAD_0040);
    dbg_write(7'd50, 32'h4000_0050);
    fetch(16'h0190, w);
    check("R5 scratch toggle word", w, 32'h4000_0050);
    check("R4 alive after scratch toggle", 32'(alive_out), 0);
    for (int i = 0; i < 6; i++) begin
      fetch_req = 1'b1; fetch_addr = 16'(16'h0100 + 8 * i);
      tick();
      check("R5 back-to-back valid", 32'(fetch_valid), 1);
    end
    fetch_req = 1'b0;
    tick();
    check("R5 no refill outside cache", 32'(mreq_count), 0);

    cur = "R6";
    dbg_write(7'h40, 32'h1);
    base = mreq_count;
    fetch(16'h1000, w);
    check("R6 miss word", w, memf(16'h1000));
    check("R6 one request", 32'(mreq_count - base), 1);
    cur = "R7";
    fetch(16'h1008, w);
    check("R7 hit word", w, memf(16'h1008));
    fetch(16'h1018, w);
    check("R7 hit last beat", w, memf(16'h1018));
    check("R7 no request on hit", 32'(mreq_count - base), 1);
    cur = "R6";
    fetch(16'h2004, w);
    check("R6 conflict miss", w, memf(16'h2000));
    fetch(16'h1008, w);
    check("R6 evicted line refetched", w, memf(16'h1008));
    check("R6 request count", 32'(mreq_count - base), 3);
    fetch(16'h1030, w);
    check("R6 second line miss", w, memf(16'h1030));

    cur = "R8";
    base = mreq_count;
    fetch(16'h1010, w);
    check("R8 hit before mode change", 32'(mreq_count - base), 0);
    dbg_write(7'h40, 32'h2);
    dbg_write(7'h40, 32'h1);
    fetch(16'h1010, w);
    check("R8 miss after mode change", 32'(mreq_count - base), 1);
    check("R8 refilled word", w, memf(16'h1010));

    cur = "R11";
    dbg_write(7'd4, 32'h0);
    dbg_write(7'd27, 32'h1234_5678);
    do_reset();
    dbg_check("R11 mode back to self-test", 7'h40, 32'd0);
    fetch(16'h0020, w);
    check("R11 boot toggle restored", w, tb_boot(4));
    fetch(16'h00D8, w);
    check("R11 boot jump restored", w, tb_boot(27));
    check("R11 alive after one toggle", 32'(alive_out), 1);
    repeat (3) tick();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule